// File: doc/BRIEF.md
# Character Text Overlay for a 640x480 Pixel Stream

This block lays a grid of text over a pixel stream that arrives one pixel per clock in raster order, with no frame store behind it. Each pixel comes with its screen coordinates, an active-video flag and a colour. The block turns the coordinates into a character cell, fetches the character code held for that cell in a small on-chip screen buffer, then takes the matching glyph row from a built-in font. Where the glyph has a lit pixel, the incoming colour is replaced by a fixed text colour. Everywhere else the incoming colour passes through.

Character cells are 12 lines tall and 9 pixels wide. The glyph fills only the left 8 pixels, so the ninth pixel of each cell keeps its spacing and is never drawn. A 640-pixel line holds 71 whole cells, and 480 lines hold 40 cell rows. A processor fills the screen buffer through a simple write port. The built-in font carries only a handful of glyphs. Every other code draws nothing.

The screen-buffer read and the glyph lookup take two clock cycles. The active flag and the colour are delayed by the same two cycles, so the output stays aligned with the input stream.

Top module: `text_overlay`

## Requirements
- R1: While reset is held, `out_active` is 0 and `out_rgb` is 0, whatever the pixel inputs are.
- R2: `out_active` equals `pix_active` from two clocks earlier. On an active pixel that draws no text, `out_rgb` equals `pix_rgb` from two clocks earlier.
- R3: A pixel at (x, y) belongs to the cell at column x/9 and row y/12. That cell's code is stored at buffer address row*71 + column. Inside the cell, the glyph row is y mod 12 and the pixel column is x mod 9. Glyph bit 7 is pixel column 0 and bit 0 is pixel column 7.
- R4: Pixel column 8 of every cell never draws text.
- R5: Pixels with x of 639 or more lie past the last whole cell and never draw text.
- R6: The built-in glyphs are as follows. Code 0x2D lights all 8 pixels of glyph row 5. Code 0x3D lights all 8 pixels of glyph rows 4 and 7. Code 0x5F lights all 8 pixels of glyph row 11. Code 0x7C lights pixel columns 3 and 4 (bits 8'h18) on all 12 glyph rows.
- R7: Code 0x20 and every code not listed in R6 draws no pixels.
- R8: On an active pixel where the glyph bit is lit, `out_rgb` is the text colour `TEXT_RGB`, which defaults to 24'hFFD000.
- R9: When `pix_active` was 0 two clocks earlier, `out_rgb` is 0.
- R10: When `wr_en` is high at a clock edge, `wr_data` is stored at `wr_addr`. The new code is used for every read from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_x | input | 10 | Horizontal coordinate of the incoming pixel |
| pix_y | input | 10 | Vertical coordinate of the incoming pixel |
| pix_active | input | 1 | Incoming pixel lies in the visible area |
| pix_rgb | input | 24 | Incoming pixel colour |
| wr_en | input | 1 | Screen-buffer write strobe |
| wr_addr | input | 12 | Screen-buffer cell address (row*71 + column) |
| wr_data | input | 8 | Character code to store |
| out_active | output | 1 | Active flag delayed by two clocks |
| out_rgb | output | 24 | Mixed output colour |

## Verification
The assertions assume that `pix_active` is low during reset. They also assume that the screen buffer is not written at the same address the stream is reading in that cycle, because a read in that cycle returns the old code. The bench holds the stream idle during reset and while it loads the buffer. It only changes codes between sweeps, with two idle pixels before each sweep restarts. Coordinates outside the grid are sent only with the active flag low, except x = 639, which the bench sends on purpose to check R5.

// File: rtl/text_overlay_pkg.sv
package text_overlay_pkg;
  localparam int H_ACTIVE = 640;
  localparam int V_ACTIVE = 480;
  localparam int CELL_W   = 9;
  localparam int GLYPH_W  = 8;
  localparam int GLYPH_H  = 12;
  localparam int CODE_W   = 8;
  localparam int COORD_W  = $clog2(H_ACTIVE);
  localparam int SUB_W    = $clog2(GLYPH_H);
  localparam int COLS     = H_ACTIVE / CELL_W;
  localparam int ROWS     = V_ACTIVE / GLYPH_H;
  localparam int DEPTH    = COLS * ROWS;
  localparam int ADDR_W   = $clog2(DEPTH);
  localparam int GRID_W   = COLS * CELL_W;
  localparam int GRID_H   = ROWS * GLYPH_H;

  // Buffer address of the cell that holds pixel (x, y).
  function automatic logic [ADDR_W-1:0] cell_addr(input logic [COORD_W-1:0] x,
                                                  input logic [COORD_W-1:0] y);
    int c;
    int r;
    c = int'(x) / CELL_W;
    r = int'(y) / GLYPH_H;
    return ADDR_W'(r * COLS + c);
  endfunction

  function automatic logic [SUB_W-1:0] col_in_cell(input logic [COORD_W-1:0] x);
    return SUB_W'(int'(x) % CELL_W);
  endfunction

  function automatic logic [SUB_W-1:0] row_in_cell(input logic [COORD_W-1:0] y);
    return SUB_W'(int'(y) % GLYPH_H);
  endfunction

  // Built-in glyph subset. Bit GLYPH_W-1 is the leftmost pixel.
  function automatic logic [GLYPH_W-1:0] glyph_bits(input logic [CODE_W-1:0] code,
                                                    input logic [SUB_W-1:0] row);
    logic [GLYPH_W-1:0] g;
    case (code)
      8'h2D:   g = (row == SUB_W'(5)) ? '1 : '0;
      8'h3D:   g = (row == SUB_W'(4) || row == SUB_W'(7)) ? '1 : '0;
      8'h5F:   g = (row == SUB_W'(11)) ? '1 : '0;
      8'h7C:   g = GLYPH_W'(8'h18);
      default: g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/tovl_screen_buf.sv
module tovl_screen_buf
  import text_overlay_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CODE_W-1:0] rd_code
);
  logic [CODE_W-1:0] mem [DEPTH];
  logic wr_in_range;

  assign wr_in_range = wr_addr < ADDR_W'(DEPTH);

  // R10: write port; synchronous read returns the old code on a same-cycle collision
  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) mem[wr_addr] <= wr_data;
    rd_code <= mem[rd_addr];
  end

  // R3
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr < ADDR_W'(DEPTH));
endmodule

// File: rtl/tovl_font_rom.sv
module tovl_font_rom
  import text_overlay_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [SUB_W-1:0]  row,
  input  logic [SUB_W-1:0]  col,
  input  logic              in_grid,
  output logic              hit
);
  logic [GLYPH_W-1:0] bits;
  logic [GLYPH_W-1:0] shifted;
  logic               glyph_col;

  always_comb begin
    bits      = glyph_bits(code, row);
    shifted   = bits << col;
    glyph_col = col < SUB_W'(GLYPH_W);
    hit       = in_grid && glyph_col && shifted[GLYPH_W-1];
  end
endmodule

// File: rtl/tovl_mixer.sv
module tovl_mixer
  import text_overlay_pkg::*;
#(
  parameter int               RGB_W    = 24,
  parameter logic [RGB_W-1:0] TEXT_RGB = 24'hFFD000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [SUB_W-1:0] col,
  input  logic             active,
  input  logic [RGB_W-1:0] rgb,
  output logic             out_active,
  output logic [RGB_W-1:0] out_rgb
);
  logic             s2_hit;
  logic             s2_active;
  logic [RGB_W-1:0] s2_rgb;
  logic             ninth_col;

  assign ninth_col = col == SUB_W'(GLYPH_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_hit    <= 1'b0;
      s2_active <= 1'b0;
      s2_rgb    <= '0;
    end else begin
      s2_hit    <= hit;
      s2_active <= active;
      s2_rgb    <= rgb;
    end
  end

  always_comb begin
    out_active = s2_active;
    if (!s2_active)  out_rgb = '0;
    else if (s2_hit) out_rgb = TEXT_RGB;
    else             out_rgb = s2_rgb;
  end

  // R4
  ninth_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ninth_col |=> !s2_hit);
endmodule

// File: rtl/text_overlay.sv
module text_overlay
  import text_overlay_pkg::*;
#(
  parameter int               RGB_W    = 24,
  parameter logic [RGB_W-1:0] TEXT_RGB = 24'hFFD000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic               pix_active,
  input  logic [RGB_W-1:0]   pix_rgb,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CODE_W-1:0]  wr_data,
  output logic               out_active,
  output logic [RGB_W-1:0]   out_rgb
);
  logic              in_grid;
  logic [ADDR_W-1:0] rd_addr;
  logic [CODE_W-1:0] s1_code;
  logic [SUB_W-1:0]  s1_row;
  logic [SUB_W-1:0]  s1_col;
  logic              s1_grid;
  logic              s1_active;
  logic [RGB_W-1:0]  s1_rgb;
  logic              s1_hit;
  logic [1:0]        warm;
  logic              settled;

  // R3, R5: cell decode; outside the grid the read is parked at address 0
  assign in_grid = (int'(pix_x) < GRID_W) && (int'(pix_y) < GRID_H);
  assign rd_addr = in_grid ? cell_addr(pix_x, pix_y) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_row    <= '0;
      s1_col    <= '0;
      s1_grid   <= 1'b0;
      s1_active <= 1'b0;
      s1_rgb    <= '0;
    end else begin
      s1_row    <= row_in_cell(pix_y);
      s1_col    <= col_in_cell(pix_x);
      s1_grid   <= in_grid;
      s1_active <= pix_active;
      s1_rgb    <= pix_rgb;
    end
  end

  tovl_screen_buf u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_code (s1_code)
  );

  tovl_font_rom u_font (
    .code    (s1_code),
    .row     (s1_row),
    .col     (s1_col),
    .in_grid (s1_grid),
    .hit     (s1_hit)
  );

  tovl_mixer #(.RGB_W(RGB_W), .TEXT_RGB(TEXT_RGB)) u_mix (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (s1_hit),
    .col        (s1_col),
    .active     (s1_active),
    .rgb        (s1_rgb),
    .out_active (out_active),
    .out_rgb    (out_rgb)
  );

  // Cycles since reset, so that two-deep history checks never look before it.
  always_ff @(posedge clk) begin
    if (!rst_n)              warm <= 2'd0;
    else if (warm != 2'd2)   warm <= warm + 2'd1;
  end
  assign settled = warm == 2'd2;

  // R2
  active_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> out_active == $past(pix_active, 2));

  // R9
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !$past(pix_active, 2)) |-> out_rgb == '0);

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && out_active && out_rgb != TEXT_RGB) |-> out_rgb == $past(pix_rgb, 2));

  // R5
  past_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && out_active && int'($past(pix_x, 2)) >= GRID_W)
      |-> out_rgb == $past(pix_rgb, 2));
endmodule

// File: tb/text_overlay_tb.sv
module text_overlay_tb;
  localparam int          W      = 640;
  localparam int          NCOL   = 71;
  localparam int          NCELLS = 71 * 40;
  localparam logic [23:0] TXT    = 24'hFFD000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  pix_x = '0;
  logic [9:0]  pix_y = '0;
  logic        pix_active = 1'b0;
  logic [23:0] pix_rgb = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        out_active;
  logic [23:0] out_rgb;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [NCELLS];

  // Two-deep history of expected outputs, oldest in slot 2.
  logic        h1_v = 0, h2_v = 0;
  logic        h1_a, h2_a;
  logic [23:0] h1_c, h2_c;
  string       h1_t, h2_t;
  int          h1_x, h2_x, h1_y, h2_y;

  always #2 clk = ~clk;

  text_overlay u_dut (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .pix_active(pix_active), .pix_rgb(pix_rgb), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_active(out_active), .out_rgb(out_rgb)
  );

  function automatic logic [7:0] fill_code(input int a);
    case ((a * 3 + a / NCOL) % 8)
      0: return 8'h2D;
      1: return 8'h3D;
      2: return 8'h5F;
      3: return 8'h7C;
      4: return 8'h20;
      5: return 8'h41;
      6: return 8'h00;
      default: return 8'h7C;
    endcase
  endfunction

  // R6 / R7 restated per pixel rather than per row mask
  function automatic bit lit(input logic [7:0] code, input int grow, input int gcol);
    if (gcol > 7) return 0;
    if (code == 8'h2D) return grow == 5;
    if (code == 8'h3D) return grow == 4 || grow == 7;
    if (code == 8'h5F) return grow == 11;
    if (code == 8'h7C) return gcol == 3 || gcol == 4;
    return 0;
  endfunction

  function automatic logic [23:0] rgb_of(input int x, input int y);
    return {x[7:0], y[7:0], 8'h5A ^ x[7:0]};
  endfunction

  task automatic step(input int x, input int y, input bit act);
    int cx, cy, gx, gy;
    logic [23:0] e;
    string t;
    @(negedge clk);
    if (h2_v) begin
      checks++;
      if (out_active !== h2_a || out_rgb !== h2_c) begin
        fails++;
        $display("FAIL %s x=%0d y=%0d got act=%0b rgb=%h exp act=%0b rgb=%h",
                 h2_t, h2_x, h2_y, out_active, out_rgb, h2_a, h2_c);
      end
    end
    // R3 mapping: cell x/9, y/12; in-cell column x mod 9, row y mod 12
    cx = x / 9; cy = y / 12; gx = x - cx * 9; gy = y - cy * 12;
    if (!act) begin
      e = '0; t = "R9";
    end else if (x >= NCOL * 9) begin
      e = rgb_of(x, y); t = "R5";
    end else if (gx == 8) begin
      e = rgb_of(x, y); t = "R4";
    end else if (lit(shadow[cy * NCOL + cx], gy, gx)) begin
      e = TXT; t = "R6/R8 via R3";
    end else begin
      e = rgb_of(x, y); t = "R7/R2";
    end
    h2_v = h1_v; h2_a = h1_a; h2_c = h1_c; h2_t = h1_t; h2_x = h1_x; h2_y = h1_y;
    h1_v = 1;    h1_a = act;  h1_c = e;    h1_t = t;    h1_x = x;    h1_y = y;
    pix_x = 10'(x); pix_y = 10'(y); pix_active = act; pix_rgb = rgb_of(x, y);
  endtask

  task automatic drain();
    step(700, 500, 0);
    step(700, 500, 0);
    h1_v = 0; h2_v = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 12'(a); wr_data = d;
    if (a < NCELLS) shadow[a] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic sweep_line(input int y);
    for (int x = 0; x < W; x++) step(x, y, 1);
    for (int b = 0; b < 10; b++) step(W + b, y, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset holds outputs low even with an active, coloured input
    pix_active = 1; pix_rgb = 24'h123456;
    repeat (4) @(negedge clk);
    checks++;
    if (out_active !== 1'b0 || out_rgb !== 24'h0) begin
      fails++;
      $display("FAIL R1 got act=%0b rgb=%h exp act=0 rgb=000000", out_active, out_rgb);
    end
    pix_active = 0;
    @(negedge clk);
    rst_n = 1;

    // R10: fill the whole buffer
    for (int a = 0; a < NCELLS; a++) wr(a, fill_code(a));

    for (int y = 0; y < 24; y++) sweep_line(y);
    for (int y = 126; y < 138; y++) sweep_line(y);
    for (int y = 468; y < 480; y++) sweep_line(y);
    drain();

    // R10: rewrite cells and sweep again with the new codes
    wr(0, 8'h5F);
    wr(1, 8'h20);
    wr(NCOL + 70, 8'h3D);
    for (int y = 0; y < 24; y++) begin
      for (int x = 0; x < 18; x++) step(x, y, 1);
      for (int x = 621; x < W; x++) step(x, y, 1);
    end
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule